// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of one fan at a time, chosen from a bank of tachometer inputs. A controller first writes an all-zero word to the trigger port, then writes a word with a single bit set at the wanted channel. The block then waits for a qualifying edge on that channel's tach line. It counts prescaled clock ticks until the edge that closes one full fan period, and posts the count together with a sticky done flag in one 32-bit result word. Turning the count into revolutions per minute happens outside the block.

Each channel carries an enable bit and a 3-bit source select. The source select names a PWM output, and each PWM output in turn selects one of a few clock profiles. A profile holds the edge mode, the prescaler code and the window length in ticks. The channel index, edge mode, prescaler code and window length are captured at the moment a measurement starts. The tach lines are taken through a two-flop synchronizer before their edges are detected.

Top module: `fan_tach_meter`

## Requirements
- R1: The result word holds the done flag in bit 31 and the count in bits CNT_W-1:0, with every other bit zero; after reset the whole word is zero.
- R2: A measurement starts only on a trigger write that has exactly one bit set, at a channel whose enable bit is 1, and whose previous trigger write was all zeros; any other nonzero write changes nothing.
- R3: A trigger write of all zeros clears the result word to zero and abandons any measurement in progress, which then never posts a result.
- R4: The profile used by channel c is found as follows: the channel's 3-bit source select in ch_src[3c+2:3c] names PWM output p, and pwm_prof[2p+1:2p] names the profile. A profile index of NUM_PROF or more selects profile 0.
- R5: For the edge codes 00 and 01, one tick lasts D = 4 << (2 × div code) clock cycles, so the codes 0, 1, 2 and 3 give 4, 16, 64 and 256 cycles.
- R6: Edge code 00 qualifies falling edges and 01 qualifies rising edges. The count is the number of ticks after the first qualifying edge, up to and including the cycle of the next qualifying edge. A fan period of P cycles, with P a multiple of D, therefore reads P / D.
- R7: Edge code 10 qualifies both edges, halves the tick length to D / 2, and closes the measurement on the second qualifying edge after the first, so the same fan reads 2P / D, twice the single-edge count.
- R8: If no result is posted by the (unit + 1)-th tick after the start, the block posts done with a count of zero on that tick. With D = 4, done appears 4 × (unit + 1) cycles after the accepting clock edge.
- R9: Edge code 11 qualifies no edge, so the measurement always ends through R8 with a count of zero.
- R10: The count saturates at 2^CNT_W − 1 and never wraps.
- R11: Once done is set, the result word holds its value until a zero trigger write; nonzero trigger writes made meanwhile leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tach_in | input | NUM_CH | Asynchronous tachometer lines |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_src | input | NUM_CH*SRC_W | Per-channel PWM source select |
| pwm_prof | input | 2^SRC_W*PSEL_W | Per-PWM-output profile index |
| prof_mode | input | NUM_PROF*2 | Per-profile edge code (00 fall, 01 rise, 10 both, 11 none) |
| prof_div | input | NUM_PROF*DIV_W | Per-profile prescaler code |
| prof_unit | input | NUM_PROF*UNIT_W | Per-profile window length in ticks |
| trig_wr | input | 1 | Trigger write strobe |
| trig_data | input | NUM_CH | Trigger write data |
| result | output | 32 | Done flag and count |

## Verification
The bench builds the block with 16 channels, three profiles, a 2-bit prescaler code and a 16-bit window, and narrows the count to CNT_W = 8. The narrow count lets a fan period of a few hundred ticks reach the saturation point, which the 20-bit default would never reach within a usable window. Short window values let both the stopped-fan expiry and the reserved edge code finish within a few hundred cycles, and the cycle on which expiry lands is checked exactly. Each prescaler code from 0 to 2 and each edge code is used at least once, together with a stopped fan, an abort and all the forms of an ignored trigger.

// File: rtl/tach_pkg.sv
package tach_pkg;

  localparam int RES_W        = 32;
  localparam int RES_DONE_BIT = 31;

  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_BOTH = 2'b10;
  localparam logic [1:0] EDGE_NONE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_MEAS,
    ST_DONE
  } tach_state_e;

endpackage

// File: rtl/tach_edge_bank.sv
module tach_edge_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tach_in,
  output logic [NUM_CH-1:0] rise,
  output logic [NUM_CH-1:0] fall
);

  // Per line: two synchronizer stages, then one history stage.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_line
    logic [2:0] shr;

    always_ff @(posedge clk) begin
      if (rst) shr <= '0;
      else     shr <= {shr[1:0], tach_in[g]};
    end

    assign rise[g] =  shr[1] & ~shr[2];
    assign fall[g] = ~shr[1] &  shr[2];
  end

endmodule

// File: rtl/tach_cfg_sel.sv
module tach_cfg_sel #(
  parameter int NUM_CH   = 16,
  parameter int SRC_W    = 3,
  parameter int NUM_PROF = 3,
  parameter int PSEL_W   = 2,
  parameter int DIV_W    = 2,
  parameter int UNIT_W   = 16
) (
  input  logic [$clog2(NUM_CH)-1:0]      ch_idx,
  input  logic [NUM_CH*SRC_W-1:0]        ch_src,
  input  logic [(1<<SRC_W)*PSEL_W-1:0]   pwm_prof,
  input  logic [NUM_PROF*2-1:0]          prof_mode,
  input  logic [NUM_PROF*DIV_W-1:0]      prof_div,
  input  logic [NUM_PROF*UNIT_W-1:0]     prof_unit,
  output logic [1:0]                     mode,
  output logic [DIV_W-1:0]               div,
  output logic [UNIT_W-1:0]              unit
);

  logic [SRC_W-1:0]  src;
  logic [PSEL_W-1:0] psel;
  int                pidx;

  // Channel -> PWM output -> profile; out-of-range profile falls back to 0.
  always_comb begin
    src  = ch_src[int'(ch_idx)*SRC_W +: SRC_W];
    psel = pwm_prof[int'(src)*PSEL_W +: PSEL_W];
    pidx = (int'(psel) < NUM_PROF) ? int'(psel) : 0;
    mode = prof_mode[pidx*2 +: 2];
    div  = prof_div[pidx*DIV_W +: DIV_W];
    unit = prof_unit[pidx*UNIT_W +: UNIT_W];
  end

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  input  logic             both,
  output logic             tick
);

  // Largest period is 4 << (2 * (2^DIV_W - 1)).
  localparam int PRE_W = 3 + 2 * ((1 << DIV_W) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    if (both) limit = (PRE_W'(2) << {div, 1'b0}) - 1'b1;
    else      limit = (PRE_W'(4) << {div, 1'b0}) - 1'b1;
    tick = !clr && (pre_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          pre_q <= '0;
    else if (pre_q == limit) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  // R5: a tick is always at least two cycles from the next one.
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> !tick);

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SRC_W    = 3,
  parameter int NUM_PROF = 3,
  parameter int PSEL_W   = 2,
  parameter int DIV_W    = 2,
  parameter int UNIT_W   = 16,
  parameter int CNT_W    = 20
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH-1:0]              tach_in,
  input  logic [NUM_CH-1:0]              ch_en,
  input  logic [NUM_CH*SRC_W-1:0]        ch_src,
  input  logic [(1<<SRC_W)*PSEL_W-1:0]   pwm_prof,
  input  logic [NUM_PROF*2-1:0]          prof_mode,
  input  logic [NUM_PROF*DIV_W-1:0]      prof_div,
  input  logic [NUM_PROF*UNIT_W-1:0]     prof_unit,
  input  logic                           trig_wr,
  input  logic [NUM_CH-1:0]              trig_data,
  output logic [RES_W-1:0]               result
);

  localparam int             IDX_W   = $clog2(NUM_CH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [RES_W-1:0] pack_word(input logic [CNT_W-1:0] c);
    logic [RES_W-1:0] w;
    w = '0;
    w[RES_DONE_BIT] = 1'b1;
    w[CNT_W-1:0]    = c;
    return w;
  endfunction

  // ---------------- edge detection ----------------
  logic [NUM_CH-1:0] rise_v, fall_v;

  tach_edge_bank #(.NUM_CH(NUM_CH)) u_edges (
    .clk     (clk),
    .rst     (rst),
    .tach_in (tach_in),
    .rise    (rise_v),
    .fall    (fall_v)
  );

  // ---------------- trigger decode ----------------
  tach_state_e       state_q;
  logic              zero_seen_q;
  logic              trig_zero, trig_onehot, start_ok;
  logic [IDX_W-1:0]  trig_idx;

  always_comb begin
    trig_zero   = trig_wr && (trig_data == '0);
    trig_onehot = (trig_data != '0) && ((trig_data & (trig_data - 1'b1)) == '0);
    trig_idx    = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (trig_data[i]) trig_idx = IDX_W'(i);
    start_ok = trig_wr && trig_onehot && zero_seen_q &&
               ((ch_en & trig_data) != '0) && (state_q == ST_IDLE);
  end

  // ---------------- profile lookup ----------------
  logic [1:0]        sel_mode;
  logic [DIV_W-1:0]  sel_div;
  logic [UNIT_W-1:0] sel_unit;

  tach_cfg_sel #(
    .NUM_CH(NUM_CH), .SRC_W(SRC_W), .NUM_PROF(NUM_PROF),
    .PSEL_W(PSEL_W), .DIV_W(DIV_W), .UNIT_W(UNIT_W)
  ) u_cfg (
    .ch_idx    (trig_idx),
    .ch_src    (ch_src),
    .pwm_prof  (pwm_prof),
    .prof_mode (prof_mode),
    .prof_div  (prof_div),
    .prof_unit (prof_unit),
    .mode      (sel_mode),
    .div       (sel_div),
    .unit      (sel_unit)
  );

  // ---------------- captured configuration ----------------
  logic [IDX_W-1:0]  ch_q;
  logic [1:0]        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [UNIT_W-1:0] unit_q;

  // ---------------- tick generation ----------------
  logic active, tick;

  assign active = (state_q == ST_ARMED) || (state_q == ST_MEAS);

  tach_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (!active),
    .div  (div_q),
    .both (mode_q == EDGE_BOTH),
    .tick (tick)
  );

  // ---------------- measurement ----------------
  logic [UNIT_W-1:0] win_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc;
  logic              half_q;
  logic              qedge, win_exp, finish;

  always_comb begin
    case (mode_q)
      EDGE_FALL: qedge = fall_v[ch_q];
      EDGE_RISE: qedge = rise_v[ch_q];
      EDGE_BOTH: qedge = rise_v[ch_q] | fall_v[ch_q];
      default:   qedge = 1'b0;
    endcase
    win_exp = tick && (win_q >= unit_q);
    cnt_inc = (tick && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
    finish  = qedge && ((mode_q != EDGE_BOTH) || half_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      zero_seen_q <= 1'b0;
      result      <= '0;
      cnt_q       <= '0;
      win_q       <= '0;
      half_q      <= 1'b0;
      ch_q        <= '0;
      mode_q      <= EDGE_FALL;
      div_q       <= '0;
      unit_q      <= '0;
    end else if (trig_zero) begin
      zero_seen_q <= 1'b1;
      state_q     <= ST_IDLE;
      result      <= '0;
      cnt_q       <= '0;
      win_q       <= '0;
      half_q      <= 1'b0;
    end else if (start_ok) begin
      zero_seen_q <= 1'b0;
      state_q     <= ST_ARMED;
      ch_q        <= trig_idx;
      mode_q      <= sel_mode;
      div_q       <= sel_div;
      unit_q      <= sel_unit;
      cnt_q       <= '0;
      win_q       <= '0;
      half_q      <= 1'b0;
    end else begin
      if (active && tick) win_q <= win_q + 1'b1;
      case (state_q)
        ST_ARMED: begin
          if (win_exp) begin
            result  <= pack_word('0);
            state_q <= ST_DONE;
          end else if (qedge) begin
            state_q <= ST_MEAS;
            cnt_q   <= '0;
            half_q  <= 1'b0;
          end
        end
        ST_MEAS: begin
          if (finish) begin
            result  <= pack_word(cnt_inc);
            state_q <= ST_DONE;
          end else if (win_exp) begin
            result  <= pack_word('0);
            state_q <= ST_DONE;
          end else begin
            cnt_q <= cnt_inc;
            if (qedge) half_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !(trig_wr && trig_onehot && zero_seen_q))
      |=> (state_q == ST_IDLE));

  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (trig_wr && trig_data == '0) |=> (result == '0 && state_q == ST_IDLE));

  assert_armed_posts_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && !trig_zero)
      |=> (!result[RES_DONE_BIT] || result[CNT_W-1:0] == '0));

  assert_count_sat_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEAS && cnt_q == CNT_MAX && !trig_zero)
      |=> (cnt_q == CNT_MAX || state_q != ST_MEAS));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (result[RES_DONE_BIT] && !(trig_wr && trig_data == '0))
      |=> (result[RES_DONE_BIT] && $stable(result)));

endmodule

// File: tb/fan_tach_meter_bench.sv
module fan_tach_meter_bench;

  localparam int NCH    = 16;
  localparam int SRCW   = 3;
  localparam int NPROF  = 3;
  localparam int PSW    = 2;
  localparam int DIVW   = 2;
  localparam int UNITW  = 16;
  localparam int CNTW   = 8;
  localparam int NPWM   = 1 << SRCW;
  localparam int CMAX   = (1 << CNTW) - 1;

  typedef struct packed {
    int ch;
    int src;
    int mode;
    int div;
    int unit;
    int half;
  } vec_t;

  // {channel, source, edge code, div code, window, half period in cycles}
  localparam vec_t VEC [8] = '{
    '{0,  0, 0, 0, 1000, 20},
    '{1,  1, 1, 1, 200,  160},
    '{2,  2, 2, 0, 300,  20},
    '{15, 7, 0, 2, 50,   320},
    '{9,  4, 1, 0, 1000, 6},
    '{6,  5, 2, 1, 400,  48},
    '{12, 3, 0, 0, 1000, 600},
    '{4,  6, 2, 0, 1000, 600}
  };

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NCH-1:0]          tach = '1;
  logic [NCH-1:0]          ch_en = '1;
  logic [NCH*SRCW-1:0]     ch_src = '0;
  logic [NPWM*PSW-1:0]     pwm_prof = '0;
  logic [NPROF*2-1:0]      prof_mode = '0;
  logic [NPROF*DIVW-1:0]   prof_div = '0;
  logic [NPROF*UNITW-1:0]  prof_unit = '0;
  logic                    trig_wr = 1'b0;
  logic [NCH-1:0]          trig_data = '0;
  logic [31:0]             result;

  int half_per [NCH];
  int fcnt     [NCH];
  int n_checks = 0;
  int n_err    = 0;

  always #5 clk = ~clk;

  fan_tach_meter #(
    .NUM_CH(NCH), .SRC_W(SRCW), .NUM_PROF(NPROF), .PSEL_W(PSW),
    .DIV_W(DIVW), .UNIT_W(UNITW), .CNT_W(CNTW)
  ) u_fan_tach_meter (
    .clk(clk), .rst(rst), .tach_in(tach), .ch_en(ch_en), .ch_src(ch_src),
    .pwm_prof(pwm_prof), .prof_mode(prof_mode), .prof_div(prof_div),
    .prof_unit(prof_unit), .trig_wr(trig_wr), .trig_data(trig_data),
    .result(result)
  );

  // Fan models: a half period of 0 means a stopped fan held high.
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (half_per[c] == 0) begin
        tach[c] <= 1'b1;
        fcnt[c] <= 0;
      end else if (fcnt[c] >= half_per[c] - 1) begin
        fcnt[c] <= 0;
        tach[c] <= ~tach[c];
      end else begin
        fcnt[c] <= fcnt[c] + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic write_trig(input logic [NCH-1:0] d);
    @(negedge clk);
    trig_wr   = 1'b1;
    trig_data = d;
    @(negedge clk);
    trig_wr   = 1'b0;
    trig_data = '0;
  endtask

  task automatic wait_done(input int limit, output logic [31:0] r, output int cyc);
    cyc = 0;
    r   = result;
    while (!r[31] && cyc < limit) begin
      @(negedge clk);
      cyc++;
      r = result;
    end
  endtask

  task automatic set_profile(input int p, input int mode, input int div, input int unit);
    prof_mode[p*2 +: 2]         = 2'(mode);
    prof_div[p*DIVW +: DIVW]    = DIVW'(div);
    prof_unit[p*UNITW +: UNITW] = UNITW'(unit);
  endtask

  // Expected count from R5, R6, R7, R9 and R10.
  function automatic logic [31:0] expect_word(input int mode, input int div, input int period);
    int d, c;
    d = 4 << (2 * div);
    if (mode == 3)      c = 0;
    else if (mode == 2) c = (2 * period) / d;
    else                c = period / d;
    if (c > CMAX) c = CMAX;
    return 32'h8000_0000 | 32'(c);
  endfunction

  function automatic logic [NCH-1:0] bit_of(input int ch);
    return NCH'(1) << ch;
  endfunction

  initial begin
    logic [31:0] r, hold;
    int cyc;
    for (int c = 0; c < NCH; c++) begin
      half_per[c] = 0;
      fcnt[c]     = 0;
    end
    // PWM output k uses profile k mod 3 (R4 routing).
    for (int k = 0; k < NPWM; k++) pwm_prof[k*PSW +: PSW] = PSW'(k % 3);
    for (int c = 0; c < NCH; c++)  ch_src[c*SRCW +: SRCW] = SRCW'(c % NPWM);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", result, 32'h0);

    // R2: one-hot write straight after reset, no zero write before it.
    set_profile(0, 0, 0, 1000);
    half_per[0] = 20;
    repeat (50) @(negedge clk);
    write_trig(bit_of(0));
    repeat (400) @(negedge clk);
    check("R2 start without zero write", result, 32'h0);

    // R2: two bits set.
    write_trig('0);
    write_trig(16'h0003);
    repeat (400) @(negedge clk);
    check("R2 multi-bit trigger", result, 32'h0);

    // R2: disabled channel.
    ch_en[10] = 1'b0;
    half_per[10] = 20;
    ch_src[10*SRCW +: SRCW] = 3'd0;
    repeat (20) @(negedge clk);
    write_trig('0);
    write_trig(bit_of(10));
    repeat (400) @(negedge clk);
    check("R2 disabled channel", result, 32'h0);
    ch_en[10] = 1'b1;

    // Vector table: routing, prescaling, edge codes, saturation.
    for (int v = 0; v < 8; v++) begin
      string tag;
      logic [31:0] exp;
      ch_src[VEC[v].ch*SRCW +: SRCW] = SRCW'(VEC[v].src);
      set_profile(VEC[v].src % 3, VEC[v].mode, VEC[v].div, VEC[v].unit);
      half_per[VEC[v].ch] = VEC[v].half;
      repeat (50) @(negedge clk);
      write_trig('0);
      write_trig(bit_of(VEC[v].ch));
      wait_done(20000, r, cyc);
      exp = expect_word(VEC[v].mode, VEC[v].div, 2 * VEC[v].half);
      if (exp[CNTW-1:0] == CMAX[CNTW-1:0]) tag = "R10 saturation";
      else if (VEC[v].mode == 2)          tag = "R4 R7 both edges";
      else                                tag = "R4 R5 R6 single edge";
      check(tag, r, exp);
    end

    // R11: done word holds, and a nonzero write without zero is ignored.
    hold = result;
    repeat (300) @(negedge clk);
    check("R11 done sticky", result, hold);
    write_trig(bit_of(0));
    repeat (400) @(negedge clk);
    check("R11 retrigger ignored", result, hold);

    // R3: zero write clears, and an aborted slow measurement never posts.
    write_trig('0);
    check("R3 zero write clears", result, 32'h0);
    ch_src[12*SRCW +: SRCW] = 3'd0;
    set_profile(0, 0, 0, 1000);
    half_per[12] = 600;
    repeat (50) @(negedge clk);
    write_trig(bit_of(12));
    repeat (100) @(negedge clk);
    write_trig('0);
    repeat (3000) @(negedge clk);
    check("R3 abort", result, 32'h0);

    // R8: stopped fan, window of 51 ticks of 4 cycles.
    ch_src[11*SRCW +: SRCW] = 3'd0;
    set_profile(0, 0, 0, 50);
    half_per[11] = 0;
    repeat (50) @(negedge clk);
    write_trig('0);
    write_trig(bit_of(11));
    wait_done(2000, r, cyc);
    check("R8 stopped fan word", r, 32'h8000_0000);
    check("R8 expiry cycle", 32'(cyc), 32'(4 * 51));

    // R9: reserved edge code on a running fan.
    ch_src[1*SRCW +: SRCW] = 3'd1;
    set_profile(1, 3, 0, 40);
    half_per[1] = 10;
    repeat (50) @(negedge clk);
    write_trig('0);
    write_trig(bit_of(1));
    wait_done(2000, r, cyc);
    check("R9 reserved edge code", r, 32'h8000_0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule